// File: doc/BRIEF.md
# Palette Colour Write Sequencer

This block takes the byte stream that software writes to a palette data port and turns it into whole-colour updates of a 256-entry palette memory. Three consecutive data writes carry red, green and blue. The first two are held in staging registers. The third one writes the full 24-bit triple into the entry selected by the current palette index, and the index then steps to the next entry. A separate index-port write chooses the starting entry and restarts the colour sequence.

Two protection inputs, driven from attribute-register bits elsewhere in the chip, can freeze the palette contents. While either one is set, data writes still move the colour position and the index forward, but they capture no component and write nothing to memory. An optional shift moves each data byte left by two bits so that 6-bit software values fill the top of an 8-bit component. A registered read port returns one entry per cycle. In 6-bit mode that port masks each component to its low six bits.

Top module: `pal_wr_seq`

## Requirements
- R1: After a synchronous active-low reset, `ram_we` is 0, `rd_data` is 0, the colour position is red and the index is 0, so the first complete triple lands in entry 0.
- R2: Data writes are taken in the order red, green, blue. The committed word packs red in bits [23:16], green in [15:8] and blue in [7:0].
- R3: `ram_we` is high for exactly one cycle, in the cycle after the clock edge that accepted the blue write. `ram_waddr` holds the index in effect for that triple.
- R4: After each blue write the index increments modulo 256, so entry 255 is followed by entry 0.
- R5: An index-port write loads the index from `idx_val` and returns the colour position to red. Any partly written triple is abandoned.
- R6: When `idx_wr` and `dat_wr` are both high in the same cycle, the index write takes effect and the data byte is ignored.
- R7: While `guard_a` is high, a data write captures no component and produces no memory write, but the colour position and the index still advance. A red or green value held from an earlier write is kept.
- R8: `guard_b` has the same effect as `guard_a`, on its own and independently of it.
- R9: With `shift_en` high, each data byte is shifted left by two bits before use, and bits shifted out of the top are lost.
- R10: With `six_bit` high, `rd_data` carries each component with its top two bits forced to 0. With `six_bit` low, all eight bits are returned.
- R11: `rd_data` shows the entry addressed by `rd_addr` one clock edge after that address is applied, and does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_wr | input | 1 | Index-port write strobe |
| idx_val | input | 8 | New palette index |
| dat_wr | input | 1 | Data-port write strobe |
| dat_val | input | 8 | Colour component byte |
| shift_en | input | 1 | Shift each data byte left by two |
| six_bit | input | 1 | 6-bit component mode for the read port |
| guard_a | input | 1 | Palette protection, first source |
| guard_b | input | 1 | Palette protection, second source |
| ram_we | output | 1 | Palette memory write strobe |
| ram_waddr | output | 8 | Palette memory write address |
| ram_wdata | output | 24 | Palette memory write word {red, green, blue} |
| rd_addr | input | 8 | Read-port address |
| rd_data | output | 24 | Registered read-port word |

## Verification
The bench writes triples across entry 255 to check that the index wraps to entry 0. A design with the wrong wrap would write a wrong address or miss a strobe. It starts a triple, breaks it off with an index write and then completes a new triple; a position counter that ignores the index write would commit the new triple with the wrong colours. It protects only the red byte of one triple and expects the earlier red value to survive. A design that stops the position counter under protection would shift every later colour one slot, and one that still captures under protection would store the new red value. Further tests cover a same-cycle index and data write, a shifted byte whose top bits fall off, and 6-bit reads of entries that have their top bits set.

// File: rtl/pal_pkg.sv
// Shared types for the palette write sequencer.
// Assumes: three colour slots visited in the fixed order red, green, blue.
package pal_pkg;
    typedef enum logic [1:0] {
        SLOT_RED = 2'd0,
        SLOT_GRN = 2'd1,
        SLOT_BLU = 2'd2
    } slot_e;

    // Next slot in the red -> green -> blue -> red cycle.
    function automatic slot_e slot_next(input slot_e s);
        case (s)
            SLOT_RED: slot_next = SLOT_GRN;
            SLOT_GRN: slot_next = SLOT_BLU;
            default:  slot_next = SLOT_RED;
        endcase
    endfunction
endpackage

// File: rtl/pal_seq_ctl.sv
// Colour-slot counter and palette index.
// What it does: tracks which component the next data write carries and the
// entry that the next complete triple goes to.
// Assumes: an index write outranks a data write in the same cycle; the
// protection inputs do not reach this module, so slot and index always move.
module pal_seq_ctl
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             dat_wr,
    output slot_e            slot,
    output logic [IDX_W-1:0] index,
    output logic             dat_ok
);
    // A data write counts only when no index write arrives with it.
    assign dat_ok = dat_wr && !idx_wr;

    // Move the slot on every accepted data write; load or step the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= SLOT_RED;
            index <= '0;
        end else if (idx_wr) begin
            slot  <= SLOT_RED;
            index <= idx_val;
        end else if (dat_ok) begin
            slot <= slot_next(slot);
            if (slot == SLOT_BLU) begin
                index <= index + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pal_stage.sv
// Component staging and commit strobe.
// What it does: holds red and green until blue arrives, then issues one
// registered write of the whole triple.
// Assumes: a write accepted while locked changes no staged value and makes
// no commit.
module pal_stage
    import pal_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    localparam int WORD_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_ok,
    input  slot_e             slot,
    input  logic [COMP_W-1:0] byte_in,
    input  logic              locked,
    input  logic [IDX_W-1:0]  index,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_waddr,
    output logic [WORD_W-1:0] ram_wdata
);
    logic [COMP_W-1:0] red_q;
    logic [COMP_W-1:0] grn_q;
    logic              take;

    assign take = dat_ok && !locked;

    // Capture red and green bytes into their holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q <= '0;
            grn_q <= '0;
        end else if (take) begin
            if (slot == SLOT_RED) red_q <= byte_in;
            if (slot == SLOT_GRN) grn_q <= byte_in;
        end
    end

    // Issue the one-cycle memory write when the blue byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= take && (slot == SLOT_BLU);
            if (take && (slot == SLOT_BLU)) begin
                ram_waddr <= index;
                ram_wdata <= {red_q, grn_q, byte_in};
            end
        end
    end
endmodule

// File: rtl/pal_ram.sv
// Palette memory with one write port and a registered read port.
// What it does: stores one {red, green, blue} word per entry. On read it can
// clear the top two bits of each component.
// Assumes: entries are not reset; only the read register is.
module pal_ram #(
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    localparam int WORD_W = 3 * COMP_W,
    localparam int DEPTH  = 1 << IDX_W,
    localparam int LOW_W  = COMP_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              six_bit,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] shaped;

    assign word = mem[raddr];

    // Per component: keep all bits, or only the low six in 6-bit mode.
    for (genvar c = 0; c < 3; c++) begin : g_comp
        assign shaped[c*COMP_W +: COMP_W] = six_bit
            ? {2'b00, word[c*COMP_W +: LOW_W]}
            : word[c*COMP_W +: COMP_W];
    end

    // Store committed triples.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the shaped read word.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= shaped;
    end
endmodule

// File: rtl/pal_wr_seq.sv
// Palette colour write sequencer, top level.
// What it does: applies the optional input shift and the combined protection,
// then connects the slot/index control, the staging logic and the memory.
// Assumes: all strobes are one-cycle pulses synchronous to clk.
module pal_wr_seq #(
    parameter int COMP_W = 8,
    parameter int IDX_W  = 8,
    localparam int WORD_W = 3 * COMP_W,
    localparam int SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_val,
    input  logic              dat_wr,
    input  logic [COMP_W-1:0] dat_val,
    input  logic              shift_en,
    input  logic              six_bit,
    input  logic              guard_a,
    input  logic              guard_b,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_waddr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    pal_pkg::slot_e    slot;
    logic [IDX_W-1:0]  wr_index;
    logic              dat_ok;
    logic [COMP_W-1:0] byte_eff;
    logic              locked;

    // Optional two-bit left shift of the incoming byte.
    assign byte_eff = shift_en ? (dat_val << SHIFT) : dat_val;
    // Either protection source freezes the palette.
    assign locked   = guard_a || guard_b;

    pal_seq_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .idx_val (idx_val),
        .dat_wr  (dat_wr),
        .slot    (slot),
        .index   (wr_index),
        .dat_ok  (dat_ok)
    );

    pal_stage #(.COMP_W(COMP_W), .IDX_W(IDX_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .dat_ok    (dat_ok),
        .slot      (slot),
        .byte_in   (byte_eff),
        .locked    (locked),
        .index     (wr_index),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    pal_ram #(.COMP_W(COMP_W), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .six_bit (six_bit),
        .raddr   (rd_addr),
        .rdata   (rd_data)
    );
endmodule

// File: rtl/pal_wr_seq_chk.sv
// Protocol checker for pal_wr_seq, bound to every instance.
// What it does: checks the strobe timing, its cause, the index stepping and
// the index load.
// Assumes: it sees the internal slot and index through the bind.
module pal_wr_seq_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idx_wr,
    input logic [IDX_W-1:0] idx_val,
    input logic             dat_wr,
    input logic             guard_a,
    input logic             guard_b,
    input logic             ram_we,
    input logic [IDX_W-1:0] ram_waddr,
    input logic [1:0]       slot,
    input logic [IDX_W-1:0] wr_index
);
    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R3
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(dat_wr) && !$past(idx_wr) && ($past(slot) == 2'd2)));

    // R7 and R8
    guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && (guard_a || guard_b)) |=> !ram_we);

    // R4
    index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wr_index == IDX_W'(ram_waddr + 1'b1)));

    // R5
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> ((wr_index == $past(idx_val)) && (slot == 2'd0)));
endmodule

bind pal_wr_seq pal_wr_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .idx_val   (idx_val),
    .dat_wr    (dat_wr),
    .guard_a   (guard_a),
    .guard_b   (guard_b),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .slot      (slot),
    .wr_index  (wr_index)
);

// File: tb/sim_pal_wr_seq.sv
// Scoreboard bench: the driver queues each expected memory write and the
// monitor compares it against the strobe the design produces.
module sim_pal_wr_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0;
    logic [7:0]  idx_val = '0;
    logic        dat_wr = 1'b0;
    logic [7:0]  dat_val = '0;
    logic        shift_en = 1'b0;
    logic        six_bit = 1'b0;
    logic        guard_a = 1'b0;
    logic        guard_b = 1'b0;
    logic        ram_we;
    logic [7:0]  ram_waddr;
    logic [23:0] ram_wdata;
    logic [7:0]  rd_addr = '0;
    logic [23:0] rd_data;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_wr_seq u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every strobe must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (exp_q.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R7/R8 unexpected strobe: actual %h expected none",
                         {ram_waddr, ram_wdata});
            end else begin
                check(tag_q.pop_front(), {ram_waddr, ram_wdata}, exp_q.pop_front());
            end
        end
    end

    task automatic send_byte(logic [7:0] v);
        @(negedge clk);
        dat_wr  = 1'b1;
        dat_val = v;
        @(negedge clk);
        dat_wr  = 1'b0;
    endtask

    task automatic set_index(logic [7:0] v);
        @(negedge clk);
        idx_wr  = 1'b1;
        idx_val = v;
        @(negedge clk);
        idx_wr  = 1'b0;
    endtask

    // Send three bytes; queue the expected write before the blue edge.
    task automatic triple(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                          bit expect_wr, logic [7:0] a, logic [23:0] w, string req);
        send_byte(r);
        send_byte(g);
        if (expect_wr) begin
            exp_q.push_back({a, w});
            tag_q.push_back(req);
        end
        send_byte(b);
    endtask

    task automatic read_chk(logic [7:0] a, logic [23:0] exp, string req);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        check(req, {8'h0, rd_data}, {8'h0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        check("R1 ram_we reset", {31'h0, ram_we}, 32'h0);
        check("R1 rd_data reset", {8'h0, rd_data}, 32'h0);
        rst_n = 1'b1;

        // R1 R2: first triple after reset goes to entry 0, packed r,g,b
        triple(8'h12, 8'h34, 8'h56, 1, 8'h00, 24'h123456, "R1 R2 first triple");
        // R4 R3: next entry by auto-increment
        triple(8'hAB, 8'hCD, 8'hEF, 1, 8'h01, 24'hABCDEF, "R4 R3 auto increment");

        // R4: wrap from 255 to 0
        set_index(8'hFE);
        triple(8'h01, 8'h02, 8'h03, 1, 8'hFE, 24'h010203, "R4 entry FE");
        triple(8'h04, 8'h05, 8'h06, 1, 8'hFF, 24'h040506, "R4 entry FF");
        triple(8'h07, 8'h08, 8'h09, 1, 8'h00, 24'h070809, "R4 wrap to 00");

        // R5: index write abandons a partial triple
        set_index(8'h10);
        send_byte(8'hE1);
        send_byte(8'hE2);
        set_index(8'h20);
        triple(8'h21, 8'h22, 8'h23, 1, 8'h20, 24'h212223, "R5 restart at red");

        // R6: same-cycle index and data write; data is ignored
        @(negedge clk);
        idx_wr = 1'b1; idx_val = 8'h30; dat_wr = 1'b1; dat_val = 8'h99;
        @(negedge clk);
        idx_wr = 1'b0; dat_wr = 1'b0;
        triple(8'h31, 8'h32, 8'h33, 1, 8'h30, 24'h313233, "R6 index wins");

        // R7: guard_a blocks the commit but the index still steps
        set_index(8'h40);
        guard_a = 1'b1;
        triple(8'hF1, 8'hF2, 8'hF3, 0, 8'h00, 24'h0, "R7");
        guard_a = 1'b0;
        triple(8'h41, 8'h42, 8'h43, 1, 8'h41, 24'h414243, "R7 index advanced");

        // R8: guard_b on red only keeps the held red, slot still advances
        triple(8'h11, 8'h22, 8'h33, 1, 8'h42, 24'h112233, "R8 setup");
        guard_b = 1'b1;
        send_byte(8'h44);
        guard_b = 1'b0;
        send_byte(8'h55);
        exp_q.push_back({8'h43, 24'h115566});
        tag_q.push_back("R8 red held");
        send_byte(8'h66);
        // R7 with both guards, then entry 0x45 from a clean triple
        guard_a = 1'b1; guard_b = 1'b1;
        triple(8'hAA, 8'hBB, 8'hCC, 0, 8'h00, 24'h0, "R7 R8");
        guard_a = 1'b0; guard_b = 1'b0;
        triple(8'h61, 8'h62, 8'h63, 1, 8'h45, 24'h616263, "R7 R8 index advanced");

        // R9: shifted input bytes lose their top bits
        shift_en = 1'b1;
        set_index(8'h50);
        triple(8'h3F, 8'h41, 8'hC1, 1, 8'h50, 24'hFC0404, "R9 shift");
        shift_en = 1'b0;

        // R10: 8-bit and 6-bit reads
        repeat (2) @(negedge clk);
        read_chk(8'h50, 24'hFC0404, "R10 8-bit read");
        read_chk(8'h01, 24'hABCDEF, "R10 8-bit read 01");
        six_bit = 1'b1;
        read_chk(8'h01, 24'h2B0D2F, "R10 6-bit read 01");
        read_chk(8'h50, 24'h3C0404, "R10 6-bit read 50");
        six_bit = 1'b0;
        read_chk(8'h00, 24'h070809, "R4 R10 wrapped entry");
        read_chk(8'h43, 24'h115566, "R8 stored");

        // R11: read data changes only after the next edge
        @(negedge clk);
        rd_addr = 8'h20;
        #1;
        check("R11 before edge", {8'h0, rd_data}, {8'h0, 24'h115566});
        @(negedge clk);
        check("R11 after edge", {8'h0, rd_data}, {8'h0, 24'h212223});

        repeat (4) @(negedge clk);
        check("R3 all strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule